// File: doc/BRIEF.md
# Aging-Adaptive Multiply Latency Controller

This block sits beside a variable-latency multiplier and decides, for each operand pair it accepts, whether the product will be ready after one clock or after two. It counts the zero bits of one watched operand. Many zeros mean few non-zero partial products and a short carry path, so such an operation is given one cycle. Two comparators run side by side on that count. One is lenient and needs more than `N` zeros. The other is strict and needs more than `N+1`. An aging monitor picks which of the two is used.

The block drives `not_gating`, an active-high load enable for the multiplier's input registers. A two-cycle decision lowers it for exactly one cycle. A timing-error report from the output error-detecting flops, arriving during the single execution cycle of a one-cycle operation, cancels that result and re-runs the operation over two further cycles. The aging monitor counts these reports over a window of `WIN` completed operations and clears the count at the end of each window. The first time the count in one window goes above `ERR_TH`, it raises `aged`, and from then on the strict comparator is used until reset. `done` marks the cycle at whose closing edge the multiplier result may be sampled.

The controller has six states. `ST_IDLE` means no operation is in flight. `ST_RUN1` is the single execution cycle of a one-cycle operation. `ST_TWO_A` and `ST_TWO_B` are the held cycle and the finishing cycle of a two-cycle operation. `ST_REDO_A` and `ST_REDO_B` are the two cycles of a re-execution. The transitions are as follows:
- `ST_IDLE`, `ST_RUN1` (error-free), `ST_TWO_B` and `ST_REDO_B` go to `ST_RUN1` on an accepted one-cycle operand, to `ST_TWO_A` on an accepted two-cycle operand, and otherwise to `ST_IDLE`.
- `ST_RUN1` with an error goes to `ST_REDO_A`.
- `ST_TWO_A` always goes to `ST_TWO_B`, and `ST_REDO_A` always goes to `ST_REDO_B`.

Top module: `ahl_latency_ctrl`

## Requirements
- R1: Out of reset, `not_gating` is 1, and `busy`, `done` and `aged` are 0.
- R2: An operand pair is accepted at a rising edge where `op_valid` and `not_gating` are both 1. While `aged` is 0, a watched operand with more than `N` zero bits makes a one-cycle operation. `done` is then high in the first cycle after acceptance, and `not_gating` stays 1 in that cycle.
- R3: While `aged` is 0, a watched operand with `N` or fewer zero bits makes a two-cycle operation. `not_gating` is 0 in the first cycle after acceptance and 1 in the second, and `done` is high only in the second.
- R4: `not_gating` is never low for more than two consecutive cycles. Without an error report it is low for at most one.
- R5: If `err_in` is 1 in the execution cycle of a one-cycle operation, `done` stays low in that cycle and `not_gating` is 0 in that cycle and the next. `done` then comes in the third cycle after acceptance.
- R6: `err_in` in any other cycle has no effect on latency, on `not_gating`, or on the aging error count.
- R7: The aging error count is cleared when the `WIN`-th completed operation of a window finishes (its `done` cycle), so errors from different windows never add up.
- R8: `aged` rises in the cycle after the report that takes one window's error count above `ERR_TH`, that is, after the (`ERR_TH`+1)-th report. It then stays 1 until reset.
- R9: While `aged` is 1, an operation is one-cycle only if its watched operand has more than `N+1` zero bits. The judgement uses the value of `aged` before the accepting edge.
- R10: With `WATCH_MR`=1 (the default), only `op_mr` is judged. The zero count of `op_md` has no effect on latency.
- R11: A new operand pair can be accepted at the edge that closes a `done` cycle, with no idle cycle in between. `done` implies `not_gating`.
- R12: `busy` is 1 from the first cycle after acceptance through the `done` cycle, and 0 when no operation is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A new operand pair is offered |
| op_md | input | W | Multiplicand |
| op_mr | input | W | Multiplier |
| err_in | input | 1 | Timing-error report from the output error-detecting flops |
| not_gating | output | 1 | Input-register load enable; low while the operands must be held |
| busy | output | 1 | An operation is in flight |
| done | output | 1 | The result may be sampled at the closing edge of this cycle |
| aged | output | 1 | Sticky aging flag that selects the strict judgement |

## Verification
Two cases put separate functions into the same cycle. In the first, the error report that crosses the window threshold is also the one that forces a re-execution. The bench provokes this by injecting the (`ERR_TH`+1)-th error of a window on a one-cycle operand. It checks that this operation still takes three cycles, that `aged` is set by the time the re-execution finishes, and that the very next operand, with exactly `N+1` zeros, is held for two cycles. In the second, a window-closing `done` coincides with acceptance of the next operand. Back-to-back issue provokes this. The bench judges it by whether the error budget of the new window starts from zero: two errors early in the following window must leave `aged` low.

// File: rtl/ahl_pkg.sv
package ahl_pkg;

    // Controller states; see BRIEF for the transition list.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RUN1   = 3'd1,
        ST_TWO_A  = 3'd2,
        ST_TWO_B  = 3'd3,
        ST_REDO_A = 3'd4,
        ST_REDO_B = 3'd5
    } ahl_state_e;

    // Number of judgement units running in parallel (lenient, strict).
    localparam int AHL_JUDGES = 2;

endpackage

// File: rtl/ahl_zero_counter.sv
module ahl_zero_counter #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] zeros
);

    // Combinational popcount of the inverted operand.
    always_comb begin
        zeros = '0;
        for (int i = 0; i < W; i++) begin
            zeros = zeros + CW'(~vec[i]);
        end
    end

endmodule

// File: rtl/ahl_judge.sv
module ahl_judge #(
    parameter int CW    = 5,
    parameter int LIMIT = 8
) (
    input  logic [CW-1:0] zeros,
    output logic          one_cycle
);

    // A pattern is short enough for one cycle when its zero count beats LIMIT.
    always_comb begin
        one_cycle = (int'(zeros) > LIMIT);
    end

endmodule

// File: rtl/ahl_aging_monitor.sv
module ahl_aging_monitor #(
    parameter int WIN    = 256,
    parameter int ERR_TH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic err_evt,
    input  logic op_done,
    output logic aged
);

    localparam int OCW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int ECW = $clog2(ERR_TH + 2);

    logic [OCW-1:0] op_cnt;
    logic [ECW-1:0] err_cnt;
    logic           win_last;

    always_comb begin
        win_last = op_done && (op_cnt == OCW'(WIN - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_cnt  <= '0;
            err_cnt <= '0;
            aged    <= 1'b0;
        end else begin
            if (op_done) begin
                op_cnt <= win_last ? '0 : op_cnt + OCW'(1);
            end
            // A window close and an error report never share a cycle:
            // errors are only reported in a cycle without done.
            if (win_last) begin
                err_cnt <= '0;
            end else if (err_evt && !aged) begin
                err_cnt <= err_cnt + ECW'(1);
            end
            if (err_evt && (err_cnt == ECW'(ERR_TH))) begin
                aged <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ahl_latency_ctrl.sv
module ahl_latency_ctrl
    import ahl_pkg::*;
#(
    parameter int W        = 16,
    parameter int N        = W / 2,
    parameter int WIN      = 256,
    parameter int ERR_TH   = 16,
    parameter bit WATCH_MR = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [W-1:0] op_md,
    input  logic [W-1:0] op_mr,
    input  logic         err_in,
    output logic         not_gating,
    output logic         busy,
    output logic         done,
    output logic         aged
);

    localparam int CW = $clog2(W + 1);

    logic [W-1:0]            watched;
    logic [CW-1:0]           zeros;
    logic [AHL_JUDGES-1:0]   verdict;
    logic                    judge_sel;
    ahl_state_e              state_q, state_d;
    logic                    ng_q, ng_d;
    logic                    redo_req;
    logic                    accept;
    logic                    hold_req;

    // Watched operand selection.
    assign watched = WATCH_MR ? op_mr : op_md;

    ahl_zero_counter #(.W(W), .CW(CW)) u_zc (
        .vec   (watched),
        .zeros (zeros)
    );

    // Lenient unit (g=0) and strict unit (g=1).
    for (genvar g = 0; g < AHL_JUDGES; g++) begin : g_judge
        ahl_judge #(.CW(CW), .LIMIT(N + g)) u_j (
            .zeros     (zeros),
            .one_cycle (verdict[g])
        );
    end

    assign judge_sel = aged ? verdict[1] : verdict[0];

    ahl_aging_monitor #(.WIN(WIN), .ERR_TH(ERR_TH)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_evt (redo_req),
        .op_done (done),
        .aged    (aged)
    );

    // State register and hold flop.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ng_q    <= 1'b1;
        end else begin
            state_q <= state_d;
            ng_q    <= ng_d;
        end
    end

    // Outputs and handshake.
    always_comb begin
        redo_req   = (state_q == ST_RUN1) && err_in;
        not_gating = ng_q && !redo_req;
        accept     = op_valid && not_gating;
        busy       = (state_q != ST_IDLE);
        unique case (state_q)
            ST_RUN1:   done = !err_in;
            ST_TWO_B:  done = 1'b1;
            ST_REDO_B: done = 1'b1;
            default:   done = 1'b0;
        endcase
        // Hold flop: judgement ORed with the inverted flop output.
        hold_req = accept && !judge_sel;
        ng_d     = !redo_req && (!hold_req || !ng_q);
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_TWO_B, ST_REDO_B: begin
                if (accept) state_d = judge_sel ? ST_RUN1 : ST_TWO_A;
                else        state_d = ST_IDLE;
            end
            ST_RUN1: begin
                if (err_in)      state_d = ST_REDO_A;
                else if (accept) state_d = judge_sel ? ST_RUN1 : ST_TWO_A;
                else             state_d = ST_IDLE;
            end
            ST_TWO_A:  state_d = ST_TWO_B;
            ST_REDO_A: state_d = ST_REDO_B;
            default:   state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/ahl_latency_ctrl_chk.sv
module ahl_latency_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic not_gating,
    input logic busy,
    input logic done,
    input logic aged
);

    // R4: no third consecutive low cycle of the load enable.
    assert_hold_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!not_gating && $past(!not_gating)) |=> not_gating);

    // R11: a finishing cycle always admits a new operand.
    assert_done_admits_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> not_gating);

    // R12: an unfinished operation in flight keeps the operands held.
    assert_busy_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |-> !not_gating);

    // R12: completion only while an operation is in flight.
    assert_done_in_flight_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R8: the aging flag never clears.
    assert_aged_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        aged |=> aged);

endmodule

bind ahl_latency_ctrl ahl_latency_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .not_gating (not_gating),
    .busy       (busy),
    .done       (done),
    .aged       (aged)
);

// File: tb/ahl_latency_ctrl_test.sv
`timescale 1ns/1ps
module ahl_latency_ctrl_test;

    localparam int W      = 8;
    localparam int N      = 4;
    localparam int WIN    = 8;
    localparam int ERR_TH = 2;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         op_valid;
    logic [W-1:0] op_md, op_mr;
    logic         err_in;
    logic         not_gating, busy, done, aged;

    int n_cmp  = 0;
    int n_bad  = 0;
    int cyc    = 0;
    int exp_q[$];
    // Reference model state
    int  win_ops = 0;
    int  errcnt  = 0;
    bit  aged_m  = 1'b0;

    always #4 clk = ~clk;  // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    ahl_latency_ctrl #(.W(W), .N(N), .WIN(WIN), .ERR_TH(ERR_TH), .WATCH_MR(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_md(op_md), .op_mr(op_mr),
        .err_in(err_in), .not_gating(not_gating), .busy(busy), .done(done), .aged(aged)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int zcount(input logic [W-1:0] v);
        int z = 0;
        for (int i = 0; i < W; i++) if (!v[i]) z++;
        return z;
    endfunction

    // Driver: called just after a falling edge; pushes the expected done cycle.
    task automatic issue(input logic [W-1:0] md, input logic [W-1:0] mr, input bit inj);
        int  z;
        bit  one;
        int  len;
        z   = zcount(mr);
        one = aged_m ? (z > N + 1) : (z > N);   // R9 / R2 / R3 / R10
        len = one ? (inj ? 3 : 1) : 2;          // R5 / R6
        check(not_gating == 1'b1, "R11 ready at issue", not_gating, 1);
        op_md = md; op_mr = mr; op_valid = 1'b1; err_in = 1'b0;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        err_in   = inj;
        exp_q.push_back(cyc + len - 1);
        if (one && inj) begin
            errcnt++;
            if (errcnt > ERR_TH) aged_m = 1'b1;
        end
        for (int k = 1; k <= len; k++) begin
            if (k > 1) begin
                @(negedge clk);
                err_in = 1'b0;
            end
            #2;
            check(not_gating == (k == len), "R3/R5 not_gating pattern", not_gating, int'(k == len));
            check(busy == 1'b1, "R12 busy in flight", busy, 1);
        end
        win_ops++;
        if (win_ops == WIN) begin   // R7 window close
            win_ops = 0;
            errcnt  = 0;
        end
        check(aged == aged_m, "R8 aged flag", aged, int'(aged_m));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #2;
            check(busy == 1'b0, "R12 idle busy", busy, 0);
        end
    endtask

    // Monitor / scoreboard
    initial begin
        int e;
        forever begin
            @(negedge clk);
            #2;
            if (rst_n === 1'b1 && done === 1'b1) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected done", cyc, -1);
                end else begin
                    e = exp_q.pop_front();
                    check(e == cyc, "R2/R3/R5 done cycle", cyc, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; err_in = 1'b0; op_md = '0; op_mr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check(not_gating == 1'b1, "R1 reset not_gating", not_gating, 1);
        check(busy == 1'b0, "R1 reset busy", busy, 0);
        check(done == 1'b0, "R1 reset done", done, 0);
        check(aged == 1'b0, "R1 reset aged", aged, 0);

        // Window 1 (8 operations, 2 counted errors)
        issue(8'hFF, 8'h00, 1'b0);      // R2 one-cycle
        issue(8'hFF, 8'h0F, 1'b0);      // R3 two-cycle, N zeros exactly
        issue(8'h00, 8'h07, 1'b0);      // R2 N+1 zeros, back-to-back R11
        issue(8'h00, 8'hFF, 1'b0);      // R10 md zeros ignored
        issue(8'hFF, 8'h07, 1'b1);      // R5 redo
        issue(8'hFF, 8'h0F, 1'b1);      // R6 error during held cycle ignored
        issue(8'hFF, 8'h00, 1'b1);      // R5 redo, second counted error
        issue(8'hFF, 8'h07, 1'b0);      // closes window, R7
        idle(2);

        // Window 2: two errors must not trip aging if the count was cleared
        issue(8'hFF, 8'h00, 1'b1);      // R7
        issue(8'hFF, 8'h00, 1'b1);      // R7
        for (int i = 0; i < 6; i++) issue(8'hFF, (i % 2 == 0) ? 8'h01 : 8'h3F, 1'b0);
        check(aged == 1'b0, "R7 count cleared across windows", aged, 0);

        // Window 3: third error trips aging
        issue(8'hFF, 8'h07, 1'b1);
        issue(8'hFF, 8'h07, 1'b1);
        issue(8'hFF, 8'h07, 1'b1);      // R8 crossing error, also a redo
        issue(8'hFF, 8'h07, 1'b0);      // R9 N+1 zeros now two-cycle
        issue(8'hFF, 8'h03, 1'b0);      // R9 N+2 zeros one-cycle
        for (int i = 0; i < 8; i++) issue(8'h55, (i % 3 == 0) ? 8'h01 : 8'h07, 1'b0);
        check(aged == 1'b1, "R8 aged sticky across windows", aged, 1);
        issue(8'hFF, 8'h00, 1'b1);      // R5 redo while aged
        idle(3);
        check(exp_q.size() == 0, "R2 all operations completed", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule